// File: doc/BRIEF.md
# Scratchpad Slot with FIFO Fill-Count Swap

This block occupies one 8-bit location of a UART-style register file. In its normal state the location is a plain scratchpad that the host can write and read back. It holds all ones after reset.

When the swap enable is high, the slot changes role. A host write no longer reaches the scratchpad. Instead, it loads a 2-bit count-select field. A host read returns a FIFO fill level instead of the scratchpad value. Depending on the select field, the level comes from the receive FIFO, from the transmit FIFO, or from both in turn on successive reads. The scratchpad value is held while the slot is swapped out, and it reappears when the swap enable drops.

Address decode and the FIFOs are outside the block. The parent drives a read strobe, a write strobe with data, the swap enable and the two raw level values. Read data is combinational from the current state. A read strobe only advances the alternation state at the clock edge that ends the read cycle.

Top module: `scratch_swap`

## Requirements
- R1: After reset, the scratchpad holds 0xFF, the select field is 00, and the alternation pointer points at the receive count.
- R2: With swap_en low, a write stores wr_data into the scratchpad, and rd_data shows the scratchpad whatever the select field holds.
- R3: With swap_en high, a write loads wr_data[1:0] into the select field.
- R4: Writes made with swap_en high leave the scratchpad unchanged, and its value reads back once swap_en is low again.
- R5: With swap_en high, select values 00 and 10 show the receive level and select value 01 shows the transmit level.
- R6: With swap_en high and select value 11, the first read after the select write shows the receive level, and each read strobe then alternates between transmit and receive.
- R7: The alternation pointer moves only on a read strobe that arrives while swap_en is high and the select value is 11.
- R8: A level of 256 or more is shown as 0xFF; smaller levels are shown unchanged.
- R9: A select write sets the pointer back to receive, even when a read strobe arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Host read of the slot, one cycle per read |
| wr_stb | input | 1 | Host write of the slot |
| wr_data | input | 8 | Write data |
| swap_en | input | 1 | High to swap the scratchpad for the count readback |
| rx_level | input | CW | Receive FIFO fill level |
| tx_level | input | CW | Transmit FIFO fill level |
| rd_data | output | 8 | Read data for the slot |

## Verification
The bench goes after several failure modes:
- **Alternation start.** After every select write the first read must show the receive level. A pointer that is not cleared on that write would start on transmit.
- **Same-cycle read and write.** A read strobe that arrives with a select write must not leave the pointer toggled. A design that gives the read priority fails here.
- **Stray toggling.** Read strobes in other modes, or with the swap disabled, must leave the pointer alone. A design that toggles freely would then return the wrong level on the next alternating read.
- **Saturation and scratchpad survival.** Levels at and above 256 must read as 0xFF rather than wrapping to their low byte. The scratchpad must survive writes made while swapped.

// File: rtl/scratch_swap.sv
module scratch_swap #(
  parameter int DW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          swap_en,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  output logic [DW-1:0] rd_data
);
  localparam logic [1:0] SEL_ALT = 2'b11;
  localparam logic [1:0] SEL_TX  = 2'b01;

  logic [DW-1:0] scr_q;
  logic [1:0]    sel_q;
  logic          on_tx_q;
  logic [DW-1:0] rx_sat, tx_sat;
  logic          pick_tx;

  generate
    if (CW > DW) begin : g_sat
      assign rx_sat = (|rx_level[CW-1:DW]) ? {DW{1'b1}} : rx_level[DW-1:0];
      assign tx_sat = (|tx_level[CW-1:DW]) ? {DW{1'b1}} : tx_level[DW-1:0];
    end else if (CW == DW) begin : g_same
      assign rx_sat = rx_level;
      assign tx_sat = tx_level;
    end else begin : g_ext
      assign rx_sat = {{(DW-CW){1'b0}}, rx_level};
      assign tx_sat = {{(DW-CW){1'b0}}, tx_level};
    end
  endgenerate

  assign pick_tx = (sel_q == SEL_TX) || ((sel_q == SEL_ALT) && on_tx_q);
  assign rd_data = !swap_en ? scr_q : (pick_tx ? tx_sat : rx_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q   <= {DW{1'b1}};
      sel_q   <= 2'b00;
      on_tx_q <= 1'b0;
    end else begin
      if (wr_stb && !swap_en) scr_q <= wr_data;
      if (wr_stb && swap_en) begin
        sel_q   <= wr_data[1:0];
        on_tx_q <= 1'b0;
      end else if (rd_stb && swap_en && sel_q == SEL_ALT) begin
        on_tx_q <= ~on_tx_q;
      end
    end
  end

  // R4
  scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> scr_q == $past(scr_q));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_en |=> sel_q == $past(sel_q));

  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && swap_en) |=> !on_tx_q);

  // R6
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && swap_en && sel_q == SEL_ALT) |=> on_tx_q != $past(on_tx_q));

  // R7
  ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !(rd_stb && swap_en && sel_q == SEL_ALT)) |=> $stable(on_tx_q));

  // R8
  sat_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && !pick_tx && rx_level >= CW'(1 << DW) && CW > DW) |-> rd_data == {DW{1'b1}});
endmodule

// File: tb/scratch_swap_bench.sv
`timescale 1ns/1ps
module scratch_swap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 1'b0, wr_stb = 1'b0, swap_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [8:0] rx_level = 9'd0, tx_level = 9'd0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_scr;
  logic [1:0] m_sel;
  bit         m_tx;

  always #2.5 clk = ~clk;

  scratch_swap u_scratch_swap (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .swap_en(swap_en), .rx_level(rx_level), .tx_level(tx_level), .rd_data(rd_data));

  function automatic logic [7:0] sat(input logic [8:0] v);
    return (v > 9'd255) ? 8'hFF : v[7:0];
  endfunction

  function automatic logic [7:0] expect_rd(input bit sw, input logic [8:0] rx, input logic [8:0] tx);
    if (!sw) return m_scr;
    if (m_sel == 2'b01 || (m_sel == 2'b11 && m_tx)) return sat(tx);
    return sat(rx);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [7:0] d, input bit sw,
                      input logic [8:0] rx, input logic [8:0] tx, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_stb = rd; wr_stb = wr; wr_data = d; swap_en = sw; rx_level = rx; tx_level = tx;
    #1;
    e = expect_rd(sw, rx, tx);
    check(req, rd_data, e);
    @(posedge clk);
    if (wr) begin
      if (sw) begin m_sel = d[1:0]; m_tx = 1'b0; end
      else m_scr = d;
    end else if (rd && sw && m_sel == 2'b11) begin
      m_tx = ~m_tx;
    end
  endtask

  function automatic string tag_for(input bit sw, input bit wr, input logic [8:0] rx, input logic [8:0] tx);
    if (!sw) return "R2";
    if (wr) return "R3";
    if ((m_sel == 2'b01 || (m_sel == 2'b11 && m_tx)) ? (tx > 255) : (rx > 255)) return "R8";
    if (m_sel == 2'b11) return "R6";
    return "R5";
  endfunction

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_scr = 8'hFF; m_sel = 2'b00; m_tx = 1'b0;
    #12 rst_n = 1'b1;

    // R1: reset value of the scratchpad and of the select field and pointer
    step(0, 0, 8'h00, 0, 9'd5, 9'd9, "R1");
    step(0, 0, 8'h00, 1, 9'd5, 9'd9, "R1");

    // R2: scratchpad write and readback
    step(0, 1, 8'hA5, 0, 9'd1, 9'd2, "R2");
    step(0, 0, 8'h00, 0, 9'd1, 9'd2, "R2");

    // R3 and R4: writes while swapped go to the select field only
    step(0, 1, 8'h5D, 1, 9'd3, 9'd4, "R3");
    step(0, 0, 8'h00, 1, 9'd3, 9'd4, "R3");
    step(0, 0, 8'h00, 0, 9'd3, 9'd4, "R4");

    // R5: select 10 shows the receive level
    step(0, 1, 8'h02, 1, 9'd17, 9'd40, "R5");
    step(1, 0, 8'h00, 1, 9'd17, 9'd40, "R5");

    // R6: alternating order begins on receive
    step(0, 1, 8'h03, 1, 9'd11, 9'd22, "R6");
    step(1, 0, 8'h00, 1, 9'd11, 9'd22, "R6");
    step(1, 0, 8'h00, 1, 9'd11, 9'd22, "R6");
    step(1, 0, 8'h00, 1, 9'd11, 9'd22, "R6");

    // R7: a read with swap disabled leaves the pointer alone
    step(1, 0, 8'h00, 0, 9'd11, 9'd22, "R7");
    step(0, 0, 8'h00, 1, 9'd11, 9'd22, "R7");

    // R9: a select write with a read in the same cycle clears the pointer
    step(1, 1, 8'h03, 1, 9'd11, 9'd22, "R9");
    step(0, 0, 8'h00, 1, 9'd11, 9'd22, "R9");

    // R8: levels on both sides of the saturation threshold
    step(0, 0, 8'h00, 1, 9'd256, 9'd22, "R8");
    step(0, 0, 8'h00, 1, 9'd255, 9'd22, "R8");
    step(0, 1, 8'h01, 1, 9'd0, 9'd300, "R8");
    step(0, 0, 8'h00, 1, 9'd0, 9'd511, "R8");

    for (int i = 0; i < 400; i++) begin
      bit rd, wr, sw;
      logic [7:0] d;
      logic [8:0] rx, tx;
      rd = ($urandom_range(0, 2) != 0);
      wr = ($urandom_range(0, 4) == 0);
      sw = ($urandom_range(0, 3) != 0);
      d  = 8'($urandom_range(0, 255));
      rx = 9'($urandom_range(0, 511));
      tx = 9'($urandom_range(0, 511));
      step(rd, wr, d, sw, rx, tx, tag_for(sw, wr, rx, tx));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule